// File: doc/BRIEF.md
# Oversampled Serial Receiver Front End

This block receives an asynchronous serial line using a sample clock that runs at sixteen times the bit rate, so each clock edge is one sample. The line first passes through a two-flop synchroniser. While idle, the receiver watches for a falling edge that follows a run of idle-high samples. When it finds one, it restarts its cyclic sample counter on that edge. This re-aligns the sampling grid to the incoming frame and absorbs small rate mismatch between transmitter and receiver.

The start bit is then checked by a majority vote over three early samples. A rejected start returns the receiver to idle. An accepted start leads to eight data bits, least significant first, and one stop bit. Each of these bits is taken as the majority of three samples around the middle of the bit. After the stop bit, the byte is presented for one clock together with two flags. The noise flag reports any disagreement among voting samples in the frame. The framing flag reports a low stop bit.

Top module: `serial_rx16`

## Requirements
- R1: The line input reaches the sampling logic through two flops, so the sample processed at an edge is the value driven on `rx_in` two edges earlier. Reset forces the receiver idle, forces the sample history and synchroniser high, and clears `rx_valid`, `rx_data`, `rx_noise` and `rx_frame_err`.
- R2: A cyclic counter numbers the samples of each bit 1 to 16, advances one step per clock while receiving, and wraps from 16 to 1 at each bit boundary.
- R3: A start is recognised only while idle, and only when a low sample immediately follows three consecutive high samples. A falling edge after fewer than three highs, or any edge during a frame, starts nothing.
- R4: On recognition, the counter restarts so that the low sample becomes slot 1 of the start bit. With the two synchroniser stages, `rx_valid` rises 155 edges after the first low sample is driven.
- R5: The start bit is verified from the samples at slots 3, 5 and 7. It is accepted when at least two of them are low.
- R6: When two or three of those samples are high, the start is rejected. No byte is produced, and the receiver goes back to idle and can accept the next frame.
- R7: An accepted start with exactly one high verification sample sets the noise flag for that frame.
- R8: Each data bit takes the majority of the samples at slots 7, 8 and 9. Bits arrive least significant first into `rx_data[0]` upward.
- R9: For any data or stop bit, disagreement among its three voting samples sets the noise flag for that frame.
- R10: A stop bit that votes low sets `rx_frame_err`. The byte is still delivered.
- R11: `rx_valid` is a one-clock pulse issued after slot 9 of the stop bit. `rx_data` and both flags hold their values until the next pulse. A new frame may begin right after the stop bit's slot 9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, 16 per bit period |
| rst_n | input | 1 | Active-low reset |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| rx_valid | output | 1 | One-clock pulse when a byte is ready |
| rx_data | output | 8 | Received byte |
| rx_noise | output | 1 | Voting disagreement seen in the frame |
| rx_frame_err | output | 1 | Stop bit voted low |

## Verification
The assertions assume that `rx_in` changes at most once per sample clock and that reset is applied before the first frame. Under those conditions, the counter, the re-alignment and the pulse rules can be stated purely in clock edges. The stimulus drives one line value per clock on the falling edge and holds the line high during and after reset. It gives every intended start at least three high samples beforehand. Noise is injected only at known slot positions, so the expected flags and byte follow from the slot numbers alone. Rejected starts and short-high patterns are built so that no later sample in them could form a legal start.

// File: rtl/serial_rx16.sv
module serial_rx16 #(
  parameter int DATA_BITS = 8,
  parameter int OSR       = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_in,
  output logic                 rx_valid,
  output logic [DATA_BITS-1:0] rx_data,
  output logic                 rx_noise,
  output logic                 rx_frame_err
);
  localparam int CW = $clog2(OSR + 1);
  localparam int IW = $clog2(DATA_BITS + 2);
  localparam logic [CW-1:0] SLOT_LAST = CW'(OSR);
  localparam logic [CW-1:0] SV_A = CW'(3);
  localparam logic [CW-1:0] SV_B = CW'(5);
  localparam logic [CW-1:0] SV_C = CW'(7);
  localparam logic [CW-1:0] SD_A = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] SD_B = CW'(OSR/2);
  localparam logic [CW-1:0] SD_C = CW'(OSR/2 + 1);
  localparam logic [IW-1:0] STOP_IDX = IW'(DATA_BITS + 1);

  logic [1:0]           sync;
  logic [2:0]           hist;
  logic                 busy;
  logic [CW-1:0]        cnt;
  logic [IW-1:0]        idx;
  logic                 va, vb;
  logic                 noise_acc;
  logic [DATA_BITS-1:0] shreg;

  logic       samp, qual, maj, disagree;
  logic [1:0] highs;

  assign samp     = sync[1];
  assign qual     = (hist == 3'b111) && !samp;
  assign highs    = {1'b0, va} + {1'b0, vb} + {1'b0, samp};
  assign maj      = highs[1];
  assign disagree = (highs == 2'd1) || (highs == 2'd2);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync         <= 2'b11;
      hist         <= 3'b111;
      busy         <= 1'b0;
      cnt          <= CW'(1);
      idx          <= '0;
      va           <= 1'b1;
      vb           <= 1'b1;
      noise_acc    <= 1'b0;
      shreg        <= '0;
      rx_valid     <= 1'b0;
      rx_data      <= '0;
      rx_noise     <= 1'b0;
      rx_frame_err <= 1'b0;
    end else begin
      sync     <= {sync[0], rx_in};
      hist     <= {hist[1:0], samp};
      rx_valid <= 1'b0;
      if (!busy) begin
        if (qual) begin
          busy      <= 1'b1;
          cnt       <= CW'(2);
          idx       <= '0;
          noise_acc <= 1'b0;
        end
      end else begin
        cnt <= (cnt == SLOT_LAST) ? CW'(1) : cnt + 1'b1;
        if (cnt == SLOT_LAST) idx <= idx + 1'b1;
        if (idx == '0) begin
          if (cnt == SV_A) va <= samp;
          if (cnt == SV_B) vb <= samp;
          if (cnt == SV_C) begin
            if (maj) busy <= 1'b0;
            else if (disagree) noise_acc <= 1'b1;
          end
        end else begin
          if (cnt == SD_A) va <= samp;
          if (cnt == SD_B) vb <= samp;
          if (cnt == SD_C) begin
            if (disagree) noise_acc <= 1'b1;
            if (idx == STOP_IDX) begin
              busy         <= 1'b0;
              rx_valid     <= 1'b1;
              rx_data      <= shreg;
              rx_noise     <= noise_acc | disagree;
              rx_frame_err <= !maj;
            end else begin
              shreg <= {maj, shreg[DATA_BITS-1:1]};
            end
          end
        end
      end
    end
  end

  // R2: counter stays within 1..OSR while a frame is in progress
  assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (cnt >= CW'(1) && cnt <= SLOT_LAST));

  assert_cnt_wrap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == SLOT_LAST) |=> (!busy || cnt == CW'(1)));

  assert_qual_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(hist == 3'b111 && !samp));

  assert_realign_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (cnt == CW'(2) && idx == '0));

  assert_reject_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && idx == '0 && cnt == SV_C && va && vb) |=> !busy);

  assert_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> ($stable(rx_data) && $stable(rx_frame_err) && $stable(rx_noise)));

  assert_valid_end_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> !busy);
endmodule

// File: tb/serial_rx16_tb.sv
module serial_rx16_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_in = 1'b1;
  logic       rx_valid;
  logic [7:0] rx_data;
  logic       rx_noise;
  logic       rx_frame_err;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int sent = 0;
  int got = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] data;
    logic       noise;
    logic       ferr;
    int         at;
    string      tag;
  } exp_t;
  exp_t q[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  serial_rx16 u_dut (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_noise(rx_noise), .rx_frame_err(rx_frame_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      rx_in = 1'b1;
    end
  endtask

  // smask: bit0 slot3, bit1 slot5, bit2 slot7 of the start bit driven high
  task automatic frame(input logic [7:0] d, input logic [2:0] smask, input int nb,
                       input int fb, input bit stop_low, input int gap, input string tag);
    logic line [0:159];
    exp_t e;
    for (int b = 0; b < 10; b++)
      for (int j = 0; j < 16; j++)
        line[b*16+j] = (b == 0) ? 1'b0 : (b == 9) ? !stop_low : d[b-1];
    if (smask[0]) line[2] = 1'b1;
    if (smask[1]) line[4] = 1'b1;
    if (smask[2]) line[6] = 1'b1;
    if (nb >= 0) line[(nb+1)*16+7] = !line[(nb+1)*16+7];
    if (fb >= 0) begin
      line[(fb+1)*16+6] = !line[(fb+1)*16+6];
      line[(fb+1)*16+7] = !line[(fb+1)*16+7];
    end
    e.data  = (fb >= 0) ? (d ^ (8'd1 << fb)) : d;
    e.noise = (smask != 3'b000) || (nb >= 0) || (fb >= 0);
    e.ferr  = stop_low;
    e.tag   = tag;
    @(negedge clk);
    e.at = cyc + 155;
    q.push_back(e);
    sent++;
    rx_in = line[0];
    for (int k = 1; k < 160; k++) begin
      @(negedge clk);
      rx_in = line[k];
    end
    idle(gap);
  endtask

  task automatic pattern(input int lo0, input int hi, input int lo1, input int hi_end);
    for (int i = 0; i < lo0; i++) begin @(negedge clk); rx_in = 1'b0; end
    for (int i = 0; i < hi; i++) begin @(negedge clk); rx_in = 1'b1; end
    for (int i = 0; i < lo1; i++) begin @(negedge clk); rx_in = 1'b0; end
    idle(hi_end);
  endtask

  always @(negedge clk) begin
    if (rst_n && rx_valid) begin
      got++;
      if (q.size() == 0) begin
        chk(1'b0, "R11 unexpected rx_valid", rx_data, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(rx_data == e.data, {e.tag, " data"}, rx_data, e.data);
        chk(rx_noise == e.noise, {e.tag, " noise"}, rx_noise, e.noise);
        chk(rx_frame_err == e.ferr, {e.tag, " frame_err"}, rx_frame_err, e.ferr);
        chk(cyc == e.at, "R4 R2 R1 latency", cyc, e.at);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(rx_valid == 0 && rx_data == 0 && rx_noise == 0 && rx_frame_err == 0,
        "R1 reset outputs", {rx_valid, rx_noise, rx_frame_err}, 0);
    rst_n = 1'b1;
    idle(10);
    frame(8'hA5, 3'b000, -1, -1, 0, 20, "R8 clean A5");
    frame(8'h00, 3'b000, -1, -1, 0, 20, "R8 zeros");
    frame(8'hFF, 3'b000, -1, -1, 0, 20, "R8 ones");
    frame(8'h01, 3'b000, -1, -1, 0, 20, "R8 lsb first");
    frame(8'h80, 3'b000, -1, -1, 0, 20, "R8 msb last");
    frame(8'h3C, 3'b100, -1, -1, 0, 20, "R7 start slot7 high");
    frame(8'hC3, 3'b001, -1, -1, 0, 20, "R7 R5 start slot3 high");
    frame(8'h5A, 3'b000, 3, -1, 0, 20, "R9 data noise");
    frame(8'h5A, 3'b000, -1, 5, 0, 20, "R9 R8 majority flip");
    frame(8'h5A, 3'b000, -1, -1, 1, 0, "R10 stop low");
    // R3: only two highs before a long low: must not start
    pattern(0, 2, 170, 20);
    // R6: rejected start, slots 3 and 5 high
    pattern(2, 4, 4, 30);
    // R6: rejected start, slots 5 and 7 high
    pattern(4, 12, 0, 30);
    frame(8'h69, 3'b000, -1, -1, 0, 0, "R6 after reject");
    frame(8'h96, 3'b000, -1, -1, 0, 0, "R11 back to back");
    frame(8'h55, 3'b000, -1, -1, 0, 20, "R3 R11 back to back 2");
    idle(40);
    chk(q.size() == 0, "R11 all frames delivered", q.size(), 0);
    chk(got == sent, "R6 R3 pulse count", got, sent);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule